// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small eight-bit processor core: a global interrupt enable, one bit-copy storage bit and six arithmetic flags. Several sources can change the word in the same cycle: the core's I/O-mapped load and store path, a flag-update bus from the ALU with a write enable per flag, interrupt entry and return events, dedicated enable and disable commands, and bit-store operations against a register-file byte. A fixed priority between these sources settles every conflict.

The block also provides the bit-load datapath, which places the storage bit into a chosen position of a register-file byte. It gates the interrupt requests through the global enable bit, so that the core sees no request while interrupts are off. The next value of the enable bit comes from a small selector. Its named states, in falling priority, are SRC_TAKE (cleared on interrupt entry), SRC_RETURN (set on return), SRC_CMD_CLR and SRC_CMD_SET (commands, with disable winning), SRC_IO (I/O write) and SRC_HOLD (keep the value). All register updates become visible on the clock edge after the request. Reads, bit-load results and the gated interrupt are combinational.

Top module: `psr_unit`

## Requirements
- R1: After reset the status word is 0x00. Its layout from bit 7 down to bit 0 is: interrupt enable, bit-copy storage, half carry, sign, overflow, negative, zero, carry.
- R2: A write with `io_we` high and `io_addr` equal to IO_ADDR (default 0x3F) stores all eight bits exactly as written, including a sign bit that disagrees with the overflow and negative flags. A read at IO_ADDR returns the word. Other addresses read 0 and writes to them have no effect.
- R3: An ALU update changes only the flags in bits 5..0 whose bit in `alu_flag_en` is 1. It takes the new value from the same bit of `alu_flag_val` and leaves bits 7 and 6 untouched.
- R4: When an ALU update enables the negative flag (bit 2) or the overflow flag (bit 3), the sign bit becomes the XOR of the resulting negative and overflow flags. The enable and value for bit 4 on the ALU bus are ignored.
- R5: `irq_take` clears the interrupt enable bit and overrides every other source in that cycle.
- R6: `irq_return` sets the interrupt enable bit unless `irq_take` is also high.
- R7: `cmd_ie_set` sets and `cmd_ie_clr` clears the interrupt enable bit. Disable wins when both are high, and both override an I/O write to bit 7.
- R8: An I/O write to the word overrides an ALU update of the same flags in the same cycle.
- R9: `bst_en` loads bit `bit_sel` of `rf_byte_in` into the storage bit, overriding an I/O write to bit 6.
- R10: While `bld_en` is high, `rf_byte_out` equals `rf_byte_in` with bit `bit_sel` replaced by the storage bit. Otherwise `rf_byte_out` equals `rf_byte_in`.
- R11: `irq_out` is high exactly when the interrupt enable bit is 1 and some request bit is high with its enable bit also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_we | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (0 when address does not match) |
| alu_flag_en | input | 6 | Per-flag write enables for bits 5..0 |
| alu_flag_val | input | 6 | New flag values for bits 5..0 |
| irq_take | input | 1 | Interrupt entry event |
| irq_return | input | 1 | Return-from-interrupt event |
| cmd_ie_set | input | 1 | Enable-interrupts command |
| cmd_ie_clr | input | 1 | Disable-interrupts command |
| bst_en | input | 1 | Bit store into storage bit |
| bld_en | input | 1 | Bit load from storage bit |
| bit_sel | input | 3 | Bit index for store and load |
| rf_byte_in | input | 8 | Register-file byte |
| rf_byte_out | output | 8 | Register-file byte after bit load |
| irq_req | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Individual interrupt enables |
| irq_out | output | 1 | Gated interrupt to the core |
| status_q | output | 8 | Current status word |

## Verification
The bench builds the block with NUM_IRQ = 4, ADDR_W = 6 and IO_ADDR = 0x3F. With these values the register sits at the top of the address space, and the neighbouring address 0x3E shows that decoding is exact. Four request lines allow disjoint request and enable patterns, which shows that gating needs a pending request and its own enable on the same line. Simultaneous events drive every level of the enable-bit selector against the levels below it.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int WORD_W    = 8;
    localparam int FLAG_BITS = 6;
    localparam int IDX_W     = $clog2(WORD_W);

    localparam int POS_IE  = 7;
    localparam int POS_CPY = 6;
    localparam int POS_HC  = 5;
    localparam int POS_SGN = 4;
    localparam int POS_OVF = 3;
    localparam int POS_NEG = 2;
    localparam int POS_ZER = 1;
    localparam int POS_CY  = 0;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_TAKE,
        SRC_RETURN,
        SRC_CMD_CLR,
        SRC_CMD_SET,
        SRC_IO
    } ie_src_e;
endpackage

// File: rtl/psr_ie_ctrl.sv
module psr_ie_ctrl
    import psr_pkg::*;
(
    input  logic ie_q,
    input  logic take,
    input  logic ret,
    input  logic cmd_set,
    input  logic cmd_clr,
    input  logic io_wr,
    input  logic io_bit,
    output logic ie_d
);
    ie_src_e src;

    always_comb begin
        if (take)         src = SRC_TAKE;
        else if (ret)     src = SRC_RETURN;
        else if (cmd_clr) src = SRC_CMD_CLR;
        else if (cmd_set) src = SRC_CMD_SET;
        else if (io_wr)   src = SRC_IO;
        else              src = SRC_HOLD;
    end

    always_comb begin
        unique case (src)
            SRC_TAKE:    ie_d = 1'b0;
            SRC_RETURN:  ie_d = 1'b1;
            SRC_CMD_CLR: ie_d = 1'b0;
            SRC_CMD_SET: ie_d = 1'b1;
            SRC_IO:      ie_d = io_bit;
            default:     ie_d = ie_q;
        endcase
    end
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ie,
    input  logic [NUM_IRQ-1:0] req,
    input  logic [NUM_IRQ-1:0] en,
    output logic               irq_out
);
    logic [NUM_IRQ-1:0] live;

    generate
        for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
            assign live[g] = req[g] & en[g];
        end
    endgenerate

    assign irq_out = ie & (|live);

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) !ie |-> !irq_out); // R11
    AST_GATE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (ie && ($countones(req & en) > 0)) |-> irq_out); // R11
endmodule

// File: rtl/psr_bitcopy.sv
module psr_bitcopy
    import psr_pkg::*;
(
    input  logic              cpy_bit,
    input  logic [WORD_W-1:0] rf_byte_in,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic              bld_en,
    output logic              picked_bit,
    output logic [WORD_W-1:0] rf_byte_out
);
    assign picked_bit = rf_byte_in[bit_sel];

    always_comb begin
        rf_byte_out = rf_byte_in;
        if (bld_en) rf_byte_out[bit_sel] = cpy_bit;
    end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int          NUM_IRQ = 4,
    parameter int          ADDR_W  = 6,
    parameter logic [7:0]  IO_ADDR = 8'h3F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_we,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    input  logic [5:0]         alu_flag_en,
    input  logic [5:0]         alu_flag_val,
    input  logic               irq_take,
    input  logic               irq_return,
    input  logic               cmd_ie_set,
    input  logic               cmd_ie_clr,
    input  logic               bst_en,
    input  logic               bld_en,
    input  logic [2:0]         bit_sel,
    input  logic [7:0]         rf_byte_in,
    output logic [7:0]         rf_byte_out,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               irq_out,
    output logic [7:0]         status_q
);
    localparam logic [ADDR_W-1:0] MY_ADDR = IO_ADDR[ADDR_W-1:0];

    logic [WORD_W-1:0] word_q, word_d;
    logic              io_hit, io_wr, ie_next, picked_bit;

    assign io_hit   = (io_addr == MY_ADDR);
    assign io_wr    = io_we & io_hit;
    assign io_rdata = io_hit ? word_q : '0;
    assign status_q = word_q;

    psr_ie_ctrl u_ie (
        .ie_q    (word_q[POS_IE]),
        .take    (irq_take),
        .ret     (irq_return),
        .cmd_set (cmd_ie_set),
        .cmd_clr (cmd_ie_clr),
        .io_wr   (io_wr),
        .io_bit  (io_wdata[POS_IE]),
        .ie_d    (ie_next)
    );

    psr_bitcopy u_cpy (
        .cpy_bit     (word_q[POS_CPY]),
        .rf_byte_in  (rf_byte_in),
        .bit_sel     (bit_sel),
        .bld_en      (bld_en),
        .picked_bit  (picked_bit),
        .rf_byte_out (rf_byte_out)
    );

    psr_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .ie      (word_q[POS_IE]),
        .req     (irq_req),
        .en      (irq_en),
        .irq_out (irq_out)
    );

    always_comb begin
        word_d = word_q;
        for (int i = 0; i < FLAG_BITS; i++) begin
            if (alu_flag_en[i] && (i != POS_SGN)) word_d[i] = alu_flag_val[i];
        end
        if (alu_flag_en[POS_NEG] || alu_flag_en[POS_OVF])
            word_d[POS_SGN] = word_d[POS_NEG] ^ word_d[POS_OVF];
        if (io_wr) word_d[POS_CPY:0] = io_wdata[POS_CPY:0];
        if (bst_en) word_d[POS_CPY] = picked_bit;
        word_d[POS_IE] = ie_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !status_q[POS_IE]); // R5
    AST_RETURN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_take) |=> status_q[POS_IE]); // R6
    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((alu_flag_en[POS_NEG] || alu_flag_en[POS_OVF]) && !io_wr)
        |=> (status_q[POS_SGN] == (status_q[POS_NEG] ^ status_q[POS_OVF]))); // R4
    AST_IO_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !bst_en && !irq_take && !irq_return && !cmd_ie_set && !cmd_ie_clr)
        |=> (status_q == $past(io_wdata))); // R2
    AST_ALU_SPARES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr && !bst_en && !irq_take && !irq_return && !cmd_ie_set && !cmd_ie_clr)
        |=> (status_q[7:6] == $past(status_q[7:6]))); // R3
    AST_LOAD_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rf_byte_out ^ rf_byte_in) <= 1); // R10
endmodule

// File: tb/psr_unit_tb.sv
module psr_unit_tb_top;
    localparam int NI = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_addr;
    logic       io_we;
    logic [7:0] io_wdata, io_rdata;
    logic [5:0] alu_flag_en, alu_flag_val;
    logic       irq_take, irq_return, cmd_ie_set, cmd_ie_clr, bst_en, bld_en;
    logic [2:0] bit_sel;
    logic [7:0] rf_byte_in, rf_byte_out, status_q;
    logic [NI-1:0] irq_req, irq_en;
    logic       irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    psr_unit #(.NUM_IRQ(NI), .ADDR_W(6), .IO_ADDR(8'h3F)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .alu_flag_en(alu_flag_en),
        .alu_flag_val(alu_flag_val), .irq_take(irq_take), .irq_return(irq_return),
        .cmd_ie_set(cmd_ie_set), .cmd_ie_clr(cmd_ie_clr), .bst_en(bst_en),
        .bld_en(bld_en), .bit_sel(bit_sel), .rf_byte_in(rf_byte_in),
        .rf_byte_out(rf_byte_out), .irq_req(irq_req), .irq_en(irq_en),
        .irq_out(irq_out), .status_q(status_q)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        io_addr = 6'h3F; io_we = 0; io_wdata = 0;
        alu_flag_en = 0; alu_flag_val = 0;
        irq_take = 0; irq_return = 0; cmd_ie_set = 0; cmd_ie_clr = 0;
        bst_en = 0; bld_en = 0; bit_sel = 0; rf_byte_in = 0;
        irq_req = 0; irq_en = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic io_write(logic [5:0] a, logic [7:0] d);
        io_addr = a; io_we = 1; io_wdata = d;
        step();
    endtask

    task automatic t_reset();
        chk("R1 reset word", status_q, 8'h00);
        chk("R1 reset read", io_rdata, 8'h00);
    endtask

    task automatic t_io_access();
        io_write(6'h3F, 8'h10);
        chk("R2 inconsistent sign stored", status_q, 8'h10);
        io_write(6'h3E, 8'hFF);
        chk("R2 other address write ignored", status_q, 8'h10);
        io_addr = 6'h3E; #1;
        chk("R2 other address reads 0", io_rdata, 8'h00);
        io_addr = 6'h3F; #1;
        chk("R2 read back", io_rdata, 8'h10);
        io_write(6'h3F, 8'hC3);
        chk("R2 full write", status_q, 8'hC3);
    endtask

    task automatic t_alu();
        alu_flag_en = 6'b100001; alu_flag_val = 6'b000000; step();
        chk("R3 enabled flags only", status_q, 8'hC2);
        alu_flag_en = 6'b100010; alu_flag_val = 6'b100000; step();
        chk("R3 half carry set zero cleared", status_q, 8'hE0);
        alu_flag_en = 6'b010000; alu_flag_val = 6'b010000; step();
        chk("R4 sign input ignored", status_q, 8'hE0);
        alu_flag_en = 6'b000100; alu_flag_val = 6'b000100; step();
        chk("R4 sign from negative", status_q, 8'hF4);
        alu_flag_en = 6'b001000; alu_flag_val = 6'b001000; step();
        chk("R4 sign from overflow", status_q, 8'hEC);
        io_write(6'h3F, 8'h1C);
        chk("R2 inconsistent sign kept", status_q, 8'h1C);
        alu_flag_en = 6'b001000; alu_flag_val = 6'b001000; step();
        chk("R4 sign repaired", status_q, 8'h0C);
    endtask

    task automatic t_irq_events();
        io_write(6'h3F, 8'h80);
        irq_take = 1; irq_return = 1; cmd_ie_set = 1; step();
        chk("R5 take wins", status_q, 8'h00);
        irq_return = 1; step();
        chk("R6 return sets", status_q, 8'h80);
        irq_take = 1; step();
        chk("R5 take clears", status_q, 8'h00);
        irq_return = 1; io_we = 1; io_wdata = 8'h00; step();
        chk("R6 return over io write", status_q, 8'h80);
    endtask

    task automatic t_cmds();
        cmd_ie_clr = 1; io_we = 1; io_wdata = 8'hFF; step();
        chk("R7 clear over io write", status_q, 8'h7F);
        cmd_ie_set = 1; step();
        chk("R7 set", status_q, 8'hFF);
        cmd_ie_set = 1; cmd_ie_clr = 1; step();
        chk("R7 clear wins over set", status_q, 8'h7F);
        cmd_ie_set = 1; io_we = 1; io_wdata = 8'h00; step();
        chk("R7 set over io write", status_q, 8'h80);
    endtask

    task automatic t_io_vs_alu();
        io_we = 1; io_wdata = 8'h01; alu_flag_en = 6'h3F; alu_flag_val = 6'h3F; step();
        chk("R8 io write beats alu", status_q, 8'h01);
    endtask

    task automatic t_bit_store();
        rf_byte_in = 8'hA5; bit_sel = 3'd5; bst_en = 1; step();
        chk("R9 store one", status_q, 8'h41);
        rf_byte_in = 8'hA5; bit_sel = 3'd1; bst_en = 1; step();
        chk("R9 store zero", status_q, 8'h01);
        rf_byte_in = 8'hA5; bit_sel = 3'd0; bst_en = 1; io_we = 1; io_wdata = 8'h00; step();
        chk("R9 store over io write", status_q, 8'h40);
    endtask

    task automatic t_bit_load();
        rf_byte_in = 8'h00; bit_sel = 3'd7; bld_en = 1; #1;
        chk("R10 load bit7", rf_byte_out, 8'h80);
        bit_sel = 3'd3; #1;
        chk("R10 load bit3", rf_byte_out, 8'h08);
        bld_en = 0; #1;
        chk("R10 pass through", rf_byte_out, 8'h00);
        step();
        io_write(6'h3F, 8'h00);
        rf_byte_in = 8'hFF; bit_sel = 3'd0; bld_en = 1; #1;
        chk("R10 load zero", rf_byte_out, 8'hFE);
        step();
    endtask

    task automatic t_gate();
        irq_req = 4'b1111; irq_en = 4'b1111; #1;
        chk("R11 blocked when disabled", {7'd0, irq_out}, 8'h00);
        step();
        io_write(6'h3F, 8'h80);
        irq_req = 4'b0101; irq_en = 4'b1010; #1;
        chk("R11 no matching line", {7'd0, irq_out}, 8'h00);
        irq_en = 4'b0100; #1;
        chk("R11 matching line", {7'd0, irq_out}, 8'h01);
        irq_req = 4'b0000; #1;
        chk("R11 no request", {7'd0, irq_out}, 8'h00);
        step();
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_io_access();
        t_alu();
        t_irq_events();
        t_cmds();
        t_io_vs_alu();
        t_bit_store();
        t_bit_load();
        t_gate();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule